// File: doc/BRIEF.md
# SDRAM Read/Write Data Path

This block is the data side of a single-data-rate SDRAM controller. A separate scheduler issues the commands. The block sees those commands as one-cycle strobes (read, write, precharge, burst terminate), together with the current mode settings: CAS latency, burst length code and single-write mode. From these it works out which clock edge carries each data beat.

On writes it puts the user's data word and byte masks on the pin-side outputs for every beat of the burst, in the same cycle. On reads it captures the pin-side input word at the edge the CAS latency dictates. Each captured word gets a per-lane valid flag. A lane's flag is cleared when the controller masked that lane two clocks earlier. Both flags are cleared when a precharge or terminate ended the burst before that beat. The user side therefore only ever sees words the memory actually drove.

The scheduler issues at most one command per cycle. The CAS latency setting must not change while a read is in flight.

Top module: `sdram_dpath`

## Requirements
- R1: A read command sampled at clock edge T captures `dq_in` for beat k (k from 0) at edge T+CL+k. The word appears on `rd_data` with a non-zero `rd_valid` right after that edge.
- R2: `cas_lat3` = 0 selects CL = 2 and `cas_lat3` = 1 selects CL = 3.
- R3: `bl_code` values 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats for both reads and writes.
- R4: On reads the mask has a latency of 2. If bit j of `dqm_out` is high at edge e, then `rd_valid[j]` is low for the beat captured at edge e+2. The two lanes are independent: bit 0 covers `dq[7:0]` and bit 1 covers `dq[15:8]`.
- R5: For each write beat, in the same cycle, `dq_oe` is 1, `dq_out` equals `wdata` and `dqm_out` equals `wmask`. A write sampled at edge T drives beats over the cycles ending at edges T through T+BL-1.
- R6: With `single_wr` = 1, every write drives exactly one beat, whatever `bl_code` holds.
- R7: A precharge sampled at edge P during a read burst ends the burst. Beats captured at edge P+CL or later carry `rd_valid` = 0, and beats captured earlier are unaffected.
- R8: A terminate sampled at edge P ends a read burst the same way as R7. During a write burst it removes `dq_oe` in the cycle it is issued.
- R9: A read issued during a read burst restarts the burst from beat 0 at its own edge. A read issued during a write burst removes `dq_oe` in that cycle.
- R10: While `rst_n` is low, and after it is released, no beat is flagged valid until a read is issued after the release. `dq_oe` stays 0 when no write is active.
- R11: Outside write beats, `dq_oe` = 0, `dq_out` = 0 and `dqm_out` follows `rd_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cas_lat3 | input | 1 | 0: CAS latency 2, 1: CAS latency 3 |
| bl_code | input | 2 | Burst length code, 1 << code beats |
| single_wr | input | 1 | Writes always one beat |
| cmd_rd | input | 1 | Read command issued this cycle |
| cmd_wr | input | 1 | Write command issued this cycle |
| cmd_pre | input | 1 | Precharge command issued this cycle |
| cmd_term | input | 1 | Burst terminate issued this cycle |
| wdata | input | DW | User write word for the current beat |
| wmask | input | DW/8 | User write byte masks, 1 masks a lane |
| rd_mask | input | DW/8 | Read-side lane mask request for this cycle |
| dq_in | input | DW | Word captured from the data pins |
| dq_out | output | DW | Word driven toward the data pins |
| dq_oe | output | 1 | Data pins driven this cycle |
| dqm_out | output | DW/8 | Byte mask toward the pins |
| rd_data | output | DW | Last captured read word |
| rd_valid | output | DW/8 | Per-lane valid flags for `rd_data` |

## Verification
Reads are run at both CAS latencies and at every burst length. The input word changes every edge, so a capture one edge early or late shows up as a data mismatch. Masking a single lane on a chosen beat separates the 2-cycle read mask latency from the 0-cycle write one and from a shared-lane mistake. Precharge and terminate are issued part-way through bursts at both latencies, which tells a cut taken CL cycles after the command apart from an immediate or late one. Writes are run full-length, single-write, terminated and interrupted by a read, which separates burst counting from single-beat handling.

// File: rtl/sdram_dpath.sv
module sdram_dpath #(
  parameter int DW         = 16,
  parameter int BL_LOG_MAX = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cas_lat3,
  input  logic [1:0]      bl_code,
  input  logic            single_wr,
  input  logic            cmd_rd,
  input  logic            cmd_wr,
  input  logic            cmd_pre,
  input  logic            cmd_term,
  input  logic [DW-1:0]   wdata,
  input  logic [DW/8-1:0] wmask,
  input  logic [DW/8-1:0] rd_mask,
  input  logic [DW-1:0]   dq_in,
  output logic [DW-1:0]   dq_out,
  output logic            dq_oe,
  output logic [DW/8-1:0] dqm_out,
  output logic [DW-1:0]   rd_data,
  output logic [DW/8-1:0] rd_valid
);
  localparam int LN    = DW / 8;
  localparam int CNT_W = BL_LOG_MAX;

  logic [CNT_W-1:0] burst_m1, rd_left, wr_left;
  logic             rd_now, wr_now, rd_kill, wr_kill, hit;
  logic [2:0]       rd_pipe;
  logic [LN-1:0]    dqm_d0, dqm_d1;

  assign burst_m1 = {CNT_W{1'b1}} >> (BL_LOG_MAX - int'(bl_code));
  assign rd_kill  = cmd_pre | cmd_term | cmd_wr;
  assign wr_kill  = cmd_pre | cmd_term | cmd_rd;
  assign rd_now   = cmd_rd | ((rd_left != '0) & ~rd_kill);
  assign wr_now   = cmd_wr | ((wr_left != '0) & ~wr_kill);

  assign dq_oe   = wr_now;
  assign dq_out  = wr_now ? wdata : '0;
  assign dqm_out = wr_now ? wmask : rd_mask;
  assign hit     = cas_lat3 ? rd_pipe[2] : rd_pipe[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_left <= '0;
      wr_left <= '0;
    end else begin
      if (cmd_rd)                          rd_left <= burst_m1;
      else if (rd_kill || rd_left == '0)   rd_left <= '0;
      else                                 rd_left <= rd_left - 1'b1;
      if (cmd_wr)                          wr_left <= single_wr ? '0 : burst_m1;
      else if (wr_kill || wr_left == '0)   wr_left <= '0;
      else                                 wr_left <= wr_left - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pipe  <= '0;
      dqm_d0   <= '0;
      dqm_d1   <= '0;
      rd_data  <= '0;
      rd_valid <= '0;
    end else begin
      rd_pipe  <= {rd_pipe[1:0], rd_now};
      dqm_d0   <= dqm_out;
      dqm_d1   <= dqm_d0;
      rd_valid <= hit ? ~dqm_d1 : '0;
      if (hit) rd_data <= dq_in;
    end
  end
endmodule

module sdram_dpath_chk #(
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cas_lat3,
  input logic            single_wr,
  input logic            cmd_rd,
  input logic            cmd_wr,
  input logic            cmd_pre,
  input logic            cmd_term,
  input logic [DW-1:0]   dq_out,
  input logic            dq_oe,
  input logic [DW/8-1:0] dqm_out,
  input logic [DW/8-1:0] rd_valid
);
  p_cl2_beat0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd && !cmd_wr && !cas_lat3 && dqm_out == '0) |-> ##3 (rd_valid == '1));

  p_cl3_beat0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd && !cmd_wr && cas_lat3) ##1 (dqm_out == '0 && cas_lat3) |-> ##3 (rd_valid == '1));

  p_rd_mask_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dqm_out[0] |-> ##3 !rd_valid[0]);

  p_single_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && single_wr) |=> (!dq_oe || cmd_wr));

  p_pre_cut_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_pre || cmd_term) && !cas_lat3) |-> ##3 (rd_valid == '0));

  p_term_cut_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_pre || cmd_term) && cas_lat3) ##1 (!cmd_rd && cas_lat3) |-> ##3 (rd_valid == '0));

  p_idle_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0));
endmodule

bind sdram_dpath sdram_dpath_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cas_lat3(cas_lat3), .single_wr(single_wr),
  .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_pre(cmd_pre), .cmd_term(cmd_term),
  .dq_out(dq_out), .dq_oe(dq_oe), .dqm_out(dqm_out), .rd_valid(rd_valid)
);

// File: tb/sdram_dpath_tb.sv
module sdram_dpath_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cas_lat3 = 1'b0;
  logic [1:0]  bl_code = 2'd0;
  logic        single_wr = 1'b0;
  logic        cmd_rd = 1'b0, cmd_wr = 1'b0, cmd_pre = 1'b0, cmd_term = 1'b0;
  logic [15:0] wdata = '0;
  logic [1:0]  wmask = '0, rd_mask = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out, rd_data;
  logic        dq_oe;
  logic [1:0]  dqm_out, rd_valid;

  int cyc = 0;
  int ncmp = 0;
  int nerr = 0;
  bit done = 1'b0;

  typedef struct {
    int          c;
    logic [15:0] d;
    logic [1:0]  v;
    string       req;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  sdram_dpath dut_i (
    .clk(clk), .rst_n(rst_n), .cas_lat3(cas_lat3), .bl_code(bl_code),
    .single_wr(single_wr), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_pre(cmd_pre),
    .cmd_term(cmd_term), .wdata(wdata), .wmask(wmask), .rd_mask(rd_mask),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .dqm_out(dqm_out),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [15:0] pat(input int c);
    logic [7:0] b = 8'(c);
    return {b ^ 8'hC3, b};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) dq_in <= pat(cyc + 1);

  always @(negedge clk) begin
    if (rst_n) begin
      while (q.size() > 0 && q[0].c < cyc) begin
        chk(1'b0, {q[0].req, " missed beat"}, 32'(rd_valid), 32'(q[0].v));
        void'(q.pop_front());
      end
      if (q.size() > 0 && q[0].c == cyc) begin
        chk(rd_valid == q[0].v, {q[0].req, " lane flags"}, 32'(rd_valid), 32'(q[0].v));
        chk(rd_data == q[0].d, {q[0].req, " data"}, 32'(rd_data), 32'(q[0].d));
        void'(q.pop_front());
      end else if (rd_valid != 2'b00) begin
        chk(1'b0, "R7/R10 unexpected beat", 32'(rd_valid), 32'h0);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == 20000 && !done) begin
      ncmp++;
      nerr++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected end earlier", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
      $finish;
    end
  end

  task automatic clear_cmds();
    cmd_rd = 0; cmd_wr = 0; cmd_pre = 0; cmd_term = 0; rd_mask = 0; wmask = 0; wdata = 0;
  endtask

  // cut_i: beat-issue offset of precharge/terminate (-1 none); mk: beat to mask (-1 none)
  task automatic run_read(input bit cl3, input logic [1:0] blc, input int cut_i,
                          input bit cut_term, input int mk, input logic [1:0] mlanes,
                          input string req);
    int cl = cl3 ? 3 : 2;
    int n  = 1 << blc;
    int t;
    logic [1:0] lanes;
    @(negedge clk); cas_lat3 = cl3; bl_code = blc;
    @(negedge clk);
    t = cyc + 1;
    for (int k = 0; k < n; k++) begin
      if (cut_i < 0 || k < cut_i) begin
        lanes = (k == mk) ? ~mlanes : 2'b11;
        if (lanes != 2'b00) q.push_back('{t + cl + k, pat(t + cl + k), lanes, req});
      end
    end
    for (int i = 0; i < cl + n + 3; i++) begin
      if (i > 0) @(negedge clk);
      cmd_rd   = (i == 0);
      cmd_pre  = (i == cut_i) && !cut_term;
      cmd_term = (i == cut_i) && cut_term;
      rd_mask  = (mk >= 0 && i == cl + mk - 2) ? mlanes : 2'b00;
    end
    @(negedge clk); clear_cmds();
    repeat (2) @(negedge clk);
  endtask

  task automatic run_write(input logic [1:0] blc, input bit single, input int term_i,
                           input string req);
    int n = single ? 1 : (1 << blc);
    bit on;
    if (term_i >= 0 && term_i < n) n = term_i;
    @(negedge clk); bl_code = blc; single_wr = single;
    for (int i = 0; i < (1 << blc) + 2; i++) begin
      if (i > 0) @(negedge clk);
      cmd_wr   = (i == 0);
      cmd_term = (i == term_i);
      wdata    = 16'h5000 + 16'(i) * 16'h0101;
      wmask    = 2'(i);
      rd_mask  = 2'(i + 1);
      #1;
      on = (i < n);
      chk(dq_oe == on, {req, " drive window"}, 32'(dq_oe), 32'(on));
      if (on) begin
        chk(dq_out == wdata && dqm_out == wmask, "R5 beat data/mask",
            {dq_out, 14'h0, dqm_out}, {wdata, 14'h0, wmask});
      end else begin
        chk(dq_out == 16'h0 && dqm_out == rd_mask, "R11 idle bus",
            {dq_out, 14'h0, dqm_out}, {16'h0, 14'h0, rd_mask});
      end
    end
    @(negedge clk); clear_cmds(); single_wr = 0;
  endtask

  initial begin
    int t;
    // R10: a read strobe held during reset must produce nothing
    cmd_rd = 1;
    repeat (3) @(negedge clk);
    cmd_rd = 0;
    #1 chk(rd_valid == 2'b00 && dq_oe == 1'b0, "R10 reset state", {rd_valid, dq_oe}, 0);
    rst_n = 1;
    repeat (6) @(negedge clk);
    chk(rd_valid == 2'b00, "R10 no beat after release", 32'(rd_valid), 0);

    run_read(1'b0, 2'd2, -1, 1'b0, -1, 2'b00, "R1 CL2 BL4");
    run_read(1'b1, 2'd3, -1, 1'b0, -1, 2'b00, "R2 CL3 BL8");
    run_read(1'b0, 2'd0, -1, 1'b0, -1, 2'b00, "R3 BL1");
    run_read(1'b1, 2'd1, -1, 1'b0, -1, 2'b00, "R3 BL2");
    run_read(1'b0, 2'd2, -1, 1'b0,  1, 2'b10, "R4 upper lane mask CL2");
    run_read(1'b1, 2'd2, -1, 1'b0,  2, 2'b01, "R4 lower lane mask CL3");
    run_read(1'b0, 2'd0, -1, 1'b0,  0, 2'b11, "R4 full mask beat0");
    run_read(1'b0, 2'd3,  3, 1'b0, -1, 2'b00, "R7 precharge cut CL2");
    run_read(1'b1, 2'd3,  5, 1'b0, -1, 2'b00, "R7 precharge cut CL3");
    run_read(1'b1, 2'd2,  1, 1'b1, -1, 2'b00, "R8 terminate cut CL3");
    run_read(1'b0, 2'd3,  2, 1'b1, -1, 2'b00, "R8 terminate cut CL2");

    // R9: read interrupting a read (CL2, BL8 then BL2 two cycles later)
    @(negedge clk); cas_lat3 = 0; bl_code = 2'd3;
    @(negedge clk);
    t = cyc + 1;
    q.push_back('{t + 2, pat(t + 2), 2'b11, "R9 first burst"});
    q.push_back('{t + 3, pat(t + 3), 2'b11, "R9 first burst"});
    cmd_rd = 1;
    @(negedge clk); cmd_rd = 0;
    @(negedge clk); cmd_rd = 1; bl_code = 2'd1;
    for (int k = 0; k < 2; k++) q.push_back('{t + 4 + k, pat(t + 4 + k), 2'b11, "R9 restarted burst"});
    @(negedge clk); cmd_rd = 0;
    repeat (10) @(negedge clk);

    run_write(2'd2, 1'b0, -1, "R5 BL4 write");
    run_write(2'd3, 1'b0, -1, "R3 BL8 write");
    run_write(2'd3, 1'b1, -1, "R6 single write");
    run_write(2'd3, 1'b0,  3, "R8 write terminate");

    // R9: read interrupting a write
    @(negedge clk); bl_code = 2'd3; cas_lat3 = 0; cmd_wr = 1;
    #1 chk(dq_oe == 1'b1, "R9 write drives", 32'(dq_oe), 1);
    @(negedge clk); cmd_wr = 0;
    #1 chk(dq_oe == 1'b1, "R9 write continues", 32'(dq_oe), 1);
    @(negedge clk);
    t = cyc + 1;
    cmd_rd = 1; bl_code = 2'd0;
    q.push_back('{t + 2, pat(t + 2), 2'b11, "R9 read after write"});
    #1 chk(dq_oe == 1'b0, "R9 read stops write", 32'(dq_oe), 0);
    @(negedge clk); cmd_rd = 0;
    #1 chk(dq_oe == 1'b0, "R9 write stays stopped", 32'(dq_oe), 0);
    repeat (8) @(negedge clk);

    chk(q.size() == 0, "R1 all beats seen", 32'(q.size()), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
    $finish;
  end
endmodule